// File: doc/BRIEF.md
# Reorder Buffer with Rename Checkpoint Recovery

This block keeps the in-flight window of an out-of-order core. Instructions enter one per cycle in program order and each receives a ring tag. Execution units report results later, in any order, as a tag and a value. The oldest entry leaves the window once its result is present. Only this retirement writes the architectural register file. A rename map beside the ring records, for each architectural register, whether a pending instruction will produce its value and under which tag.

A checkpoint of the rename map is taken whenever a predicted branch enters. Branches resolve in any order. A correctly predicted branch releases its checkpoint. A mispredicted branch discards everything younger than itself in one cycle. The allocation pointer is moved back to the slot after the branch, the map is reloaded from that branch's checkpoint, and the checkpoints of younger branches are released. Completions may carry an exception mark, which travels to retirement as a flag.

Top module: `rob_rename`

## Requirements
- R1: After synchronous reset, `alloc_ready` is 1, `alloc_tag` is 0, `cmt_valid` is 0, and every architectural register reads back as not pending.
- R2: Each accepted allocation gets the tag shown on `alloc_tag` in that cycle, and the next allocation gets that tag plus one, modulo the ring depth.
- R3: When the ring holds ROB_DEPTH entries, `alloc_ready` is 0. A ring that has been filled and then fully drained accepts again from the wrapped tag.
- R4: An accepted non-branch allocation with `alloc_wr`=1 makes its destination register read back as pending (`lkp_busy`=1) under that allocation's tag. A branch allocation never changes the map.
- R5: Retirement is strictly in tag order, one entry per cycle. An entry whose result has not arrived blocks every entry younger than it, even when their results are present.
- R6: A retiring entry presents, for one cycle, its tag, destination, write flag, the value from its completion, and `cmt_exc` equal to the exception mark given with that completion. Branches retire with `cmt_wr`=0 and `cmt_exc`=0.
- R7: After a writing entry retires, its destination reads back as not pending, with `lkp_data` equal to the retired value.
- R8: When a younger pending writer of the same register exists, the retirement of an older writer leaves the map pointing at the younger tag.
- R9: A resolution with `res_mispredict`=1 sets the next allocation tag to the branch tag plus one. No allocation is accepted in that cycle.
- R10: A misprediction restores the map as it was when the branch entered, minus any mapping whose owner has retired since then.
- R11: With every checkpoint slot (NUM_SNAPS) held, a branch allocation sees `alloc_ready`=0, while a non-branch allocation is still accepted.
- R12: A misprediction releases the checkpoint slots of the branch and of every younger branch.
- R13: A resolution with `res_mispredict`=0 releases only that branch's checkpoint slot, in whatever order the branches resolve, and marks the branch complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_branch | input | 1 | Request is a predicted branch (takes a checkpoint) |
| alloc_wr | input | 1 | Request writes a destination register |
| alloc_dest | input | AREG_W | Destination architectural register |
| alloc_ready | output | 1 | Request is accepted this cycle |
| alloc_tag | output | TAG_W | Tag given to the request |
| cmp_valid | input | 1 | Result arrives |
| cmp_tag | input | TAG_W | Tag of the completing entry |
| cmp_data | input | DATA_W | Result value |
| cmp_exc | input | 1 | Exception mark for the entry |
| res_valid | input | 1 | Branch resolution |
| res_tag | input | TAG_W | Tag of the resolving branch |
| res_mispredict | input | 1 | Branch was mispredicted |
| lookup_areg | input | AREG_W | Register to inspect |
| lkp_busy | output | 1 | Register is pending (registered, one cycle) |
| lkp_tag | output | TAG_W | Pending producer tag |
| lkp_data | output | DATA_W | Architectural value when not pending |
| cmt_valid | output | 1 | An entry retired |
| cmt_tag | output | TAG_W | Retired tag |
| cmt_wr | output | 1 | Retired entry writes a register |
| cmt_areg | output | AREG_W | Retired destination |
| cmt_data | output | DATA_W | Retired value |
| cmt_exc | output | 1 | Retired entry carried an exception mark |

## Verification
The properties assume well-formed upstream traffic. Each completion names a live, non-branch entry that has not yet completed. Each resolution names a live branch that is still unresolved. No completion targets an entry that a misprediction in the same cycle discards. The stimulus meets these conditions because it tracks every tag it was handed. It issues completions and resolutions only for tags it knows are live, and it drives at most one of them per cycle in a fixed, directed order.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int DEF_ROB_DEPTH = 8;
  localparam int DEF_NUM_AREGS = 8;
  localparam int DEF_DATA_W    = 16;
  localparam int DEF_NUM_SNAPS = 4;

  typedef enum logic {
    SLOT_FREE = 1'b0,
    SLOT_HELD = 1'b1
  } slot_state_e;
endpackage

// File: rtl/rob_sdp_ram.sv
module rob_sdp_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // read-before-write, single registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rob_snap_pool.sv
module rob_snap_pool
  import rob_pkg::*;
#(
  parameter int NUM_SNAPS = 4,
  parameter int TAG_W     = 3,
  localparam int SNAP_W = (NUM_SNAPS > 1) ? $clog2(NUM_SNAPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [TAG_W-1:0]  take_owner,
  input  logic              release_en,
  input  logic [SNAP_W-1:0] release_id,
  input  logic              flush_en,
  input  logic [TAG_W-1:0]  flush_tag,
  input  logic [TAG_W-1:0]  head_idx,
  output logic              has_free,
  output logic [SNAP_W-1:0] free_id
);
  slot_state_e      state_q [NUM_SNAPS];
  logic [TAG_W-1:0] owner_q [NUM_SNAPS];
  logic [NUM_SNAPS-1:0] kill_c;
  logic [TAG_W-1:0] flush_age;

  assign flush_age = flush_tag - head_idx;

  // a slot dies with the flush when its owner is the flushed branch or younger
  always_comb begin
    for (int s = 0; s < NUM_SNAPS; s++) begin
      kill_c[s] = flush_en && (state_q[s] == SLOT_HELD) &&
                  ((owner_q[s] - head_idx) >= flush_age);
    end
  end

  // lowest-numbered free slot wins
  always_comb begin
    free_id  = '0;
    has_free = 1'b0;
    for (int s = NUM_SNAPS - 1; s >= 0; s--) begin
      if (state_q[s] == SLOT_FREE) begin
        free_id  = SNAP_W'(s);
        has_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SNAPS; s++) state_q[s] <= SLOT_FREE;
    end else begin
      for (int s = 0; s < NUM_SNAPS; s++) begin
        if (kill_c[s] || (release_en && release_id == SNAP_W'(s))) state_q[s] <= SLOT_FREE;
        if (take && has_free && free_id == SNAP_W'(s)) begin
          state_q[s] <= SLOT_HELD;
          owner_q[s] <= take_owner;
        end
      end
    end
  end
endmodule

// File: rtl/rob_rename_map.sv
module rob_rename_map #(
  parameter int NUM_AREGS = 8,
  parameter int TAG_W     = 3,
  parameter int NUM_SNAPS = 4,
  localparam int AREG_W = (NUM_AREGS > 1) ? $clog2(NUM_AREGS) : 1,
  localparam int SNAP_W = (NUM_SNAPS > 1) ? $clog2(NUM_SNAPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AREG_W-1:0] wr_areg,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              clr_en,
  input  logic [AREG_W-1:0] clr_areg,
  input  logic [TAG_W-1:0]  clr_tag,
  input  logic              save_en,
  input  logic [SNAP_W-1:0] save_id,
  input  logic              restore_en,
  input  logic [SNAP_W-1:0] restore_id,
  input  logic [AREG_W-1:0] rd_areg,
  output logic              rd_busy,
  output logic [TAG_W-1:0]  rd_tag
);
  logic [NUM_AREGS-1:0] busy_q;
  logic [TAG_W-1:0]     tag_q [NUM_AREGS];
  logic [NUM_AREGS-1:0] sbusy_q [NUM_SNAPS];
  logic [TAG_W-1:0]     stag_q  [NUM_SNAPS][NUM_AREGS];

  logic [NUM_AREGS-1:0] cur_busy_c;
  logic [NUM_AREGS-1:0] sbusy_c [NUM_SNAPS];
  logic [NUM_AREGS-1:0] busy_d;
  logic [TAG_W-1:0]     tag_d [NUM_AREGS];

  // retirement drops a mapping only where the retiring tag still owns it,
  // in the live map and in every checkpoint
  always_comb begin
    for (int a = 0; a < NUM_AREGS; a++) begin
      cur_busy_c[a] = busy_q[a] &
        ~(clr_en && clr_areg == AREG_W'(a) && tag_q[a] == clr_tag);
    end
    for (int s = 0; s < NUM_SNAPS; s++) begin
      for (int a = 0; a < NUM_AREGS; a++) begin
        sbusy_c[s][a] = sbusy_q[s][a] &
          ~(clr_en && clr_areg == AREG_W'(a) && stag_q[s][a] == clr_tag);
      end
    end
  end

  always_comb begin
    for (int a = 0; a < NUM_AREGS; a++) begin
      busy_d[a] = restore_en ? sbusy_c[restore_id][a] : cur_busy_c[a];
      tag_d[a]  = restore_en ? stag_q[restore_id][a]  : tag_q[a];
      if (wr_en && wr_areg == AREG_W'(a)) begin
        busy_d[a] = 1'b1;
        tag_d[a]  = wr_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      for (int s = 0; s < NUM_SNAPS; s++) sbusy_q[s] <= '0;
    end else begin
      busy_q <= busy_d;
      for (int s = 0; s < NUM_SNAPS; s++) begin
        if (save_en && save_id == SNAP_W'(s)) sbusy_q[s] <= cur_busy_c;
        else                                  sbusy_q[s] <= sbusy_c[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int a = 0; a < NUM_AREGS; a++) tag_q[a] <= tag_d[a];
    for (int s = 0; s < NUM_SNAPS; s++) begin
      if (save_en && save_id == SNAP_W'(s)) begin
        for (int a = 0; a < NUM_AREGS; a++) stag_q[s][a] <= tag_q[a];
      end
    end
  end

  assign rd_busy = busy_q[rd_areg];
  assign rd_tag  = tag_q[rd_areg];
endmodule

// File: rtl/rob_rename.sv
module rob_rename
  import rob_pkg::*;
#(
  parameter int ROB_DEPTH = DEF_ROB_DEPTH,
  parameter int NUM_AREGS = DEF_NUM_AREGS,
  parameter int DATA_W    = DEF_DATA_W,
  parameter int NUM_SNAPS = DEF_NUM_SNAPS,
  localparam int TAG_W  = $clog2(ROB_DEPTH),
  localparam int PTR_W  = TAG_W + 1,
  localparam int AREG_W = (NUM_AREGS > 1) ? $clog2(NUM_AREGS) : 1,
  localparam int SNAP_W = (NUM_SNAPS > 1) ? $clog2(NUM_SNAPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic              alloc_branch,
  input  logic              alloc_wr,
  input  logic [AREG_W-1:0] alloc_dest,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              cmp_exc,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic              res_mispredict,
  input  logic [AREG_W-1:0] lookup_areg,
  output logic              lkp_busy,
  output logic [TAG_W-1:0]  lkp_tag,
  output logic [DATA_W-1:0] lkp_data,
  output logic              cmt_valid,
  output logic [TAG_W-1:0]  cmt_tag,
  output logic              cmt_wr,
  output logic [AREG_W-1:0] cmt_areg,
  output logic [DATA_W-1:0] cmt_data,
  output logic              cmt_exc
);
  // ring pointers carry one wrap bit above the index
  logic [PTR_W-1:0] head_q, tail_q;
  logic [TAG_W-1:0] head_idx, tail_idx;
  logic             ring_empty, ring_full;

  // per-entry control state
  logic [ROB_DEPTH-1:0] done_q, wr_q, br_q, exc_q;
  logic [AREG_W-1:0]    dest_q [ROB_DEPTH];
  logic [SNAP_W-1:0]    snap_q [ROB_DEPTH];

  logic              mis, res_ok, alloc_fire, alloc_writes, do_cmt;
  logic              snap_avail;
  logic [SNAP_W-1:0] snap_pick;
  logic [TAG_W-1:0]  res_age;
  logic [PTR_W-1:0]  rollback_ptr;
  logic              map_busy;
  logic [TAG_W-1:0]  map_tag;
  logic [DATA_W-1:0] arf_rdata;
  logic              byp_q;
  logic [DATA_W-1:0] byp_data_q;

  assign head_idx   = head_q[TAG_W-1:0];
  assign tail_idx   = tail_q[TAG_W-1:0];
  assign ring_empty = (head_q == tail_q);
  assign ring_full  = (head_idx == tail_idx) && (head_q[TAG_W] != tail_q[TAG_W]);

  assign mis    = res_valid && res_mispredict;
  assign res_ok = res_valid && !res_mispredict;

  assign alloc_ready  = !ring_full && !mis && (!alloc_branch || snap_avail);
  assign alloc_fire   = alloc_valid && alloc_ready;
  assign alloc_writes = alloc_fire && alloc_wr && !alloc_branch;
  assign alloc_tag    = tail_idx;

  assign do_cmt = !ring_empty && done_q[head_idx];

  // new tail sits just after the mispredicted branch
  assign res_age      = res_tag - head_idx;
  assign rollback_ptr = head_q + {1'b0, res_age} + {{TAG_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (do_cmt)          head_q <= head_q + 1'b1;
      if (mis)             tail_q <= rollback_ptr;
      else if (alloc_fire) tail_q <= tail_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
    end else begin
      if (alloc_fire) begin
        done_q[tail_idx] <= 1'b0;
        exc_q[tail_idx]  <= 1'b0;
        wr_q[tail_idx]   <= alloc_wr && !alloc_branch;
        br_q[tail_idx]   <= alloc_branch;
        dest_q[tail_idx] <= alloc_dest;
        snap_q[tail_idx] <= snap_pick;
      end
      if (cmp_valid) begin
        done_q[cmp_tag] <= 1'b1;
        exc_q[cmp_tag]  <= cmp_exc;
      end
      if (res_valid && br_q[res_tag]) begin
        done_q[res_tag] <= 1'b1;
        exc_q[res_tag]  <= 1'b0;
      end
    end
  end

  // retirement record; value comes from the result store read port
  always_ff @(posedge clk) begin
    if (rst) begin
      cmt_valid <= 1'b0;
      cmt_wr    <= 1'b0;
      cmt_exc   <= 1'b0;
    end else begin
      cmt_valid <= do_cmt;
      cmt_wr    <= do_cmt && wr_q[head_idx];
      cmt_exc   <= do_cmt && exc_q[head_idx];
    end
  end

  always_ff @(posedge clk) begin
    cmt_tag  <= head_idx;
    cmt_areg <= dest_q[head_idx];
  end

  rob_sdp_ram #(.DEPTH(ROB_DEPTH), .WIDTH(DATA_W)) u_result_store (
    .clk   (clk),
    .we    (cmp_valid),
    .waddr (cmp_tag),
    .wdata (cmp_data),
    .raddr (head_idx),
    .rdata (cmt_data)
  );

  // architectural file is written one cycle after the retirement record
  rob_sdp_ram #(.DEPTH(NUM_AREGS), .WIDTH(DATA_W)) u_arch_file (
    .clk   (clk),
    .we    (cmt_valid && cmt_wr),
    .waddr (cmt_areg),
    .wdata (cmt_data),
    .raddr (lookup_areg),
    .rdata (arf_rdata)
  );

  rob_snap_pool #(.NUM_SNAPS(NUM_SNAPS), .TAG_W(TAG_W)) u_snap_pool (
    .clk        (clk),
    .rst        (rst),
    .take       (alloc_fire && alloc_branch),
    .take_owner (tail_idx),
    .release_en (res_ok),
    .release_id (snap_q[res_tag]),
    .flush_en   (mis),
    .flush_tag  (res_tag),
    .head_idx   (head_idx),
    .has_free   (snap_avail),
    .free_id    (snap_pick)
  );

  rob_rename_map #(.NUM_AREGS(NUM_AREGS), .TAG_W(TAG_W), .NUM_SNAPS(NUM_SNAPS)) u_map (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (alloc_writes),
    .wr_areg    (alloc_dest),
    .wr_tag     (tail_idx),
    .clr_en     (do_cmt && wr_q[head_idx]),
    .clr_areg   (dest_q[head_idx]),
    .clr_tag    (head_idx),
    .save_en    (alloc_fire && alloc_branch),
    .save_id    (snap_pick),
    .restore_en (mis),
    .restore_id (snap_q[res_tag]),
    .rd_areg    (lookup_areg),
    .rd_busy    (map_busy),
    .rd_tag     (map_tag)
  );

  // lookup view: map state and file value, with a bypass for the file write in flight
  always_ff @(posedge clk) begin
    if (rst) begin
      lkp_busy <= 1'b0;
      lkp_tag  <= '0;
      byp_q    <= 1'b0;
    end else begin
      lkp_busy <= map_busy;
      lkp_tag  <= map_tag;
      byp_q    <= cmt_valid && cmt_wr && (cmt_areg == lookup_areg);
    end
    byp_data_q <= cmt_data;
  end

  assign lkp_data = byp_q ? byp_data_q : arf_rdata;
endmodule

// File: rtl/rob_rename_chk.sv
module rob_rename_chk #(
  parameter int ROB_DEPTH = 8,
  localparam int TAG_W = $clog2(ROB_DEPTH),
  localparam int PTR_W = TAG_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             res_valid,
  input logic             res_mispredict,
  input logic [TAG_W-1:0] res_tag,
  input logic             cmt_valid,
  input logic [TAG_W-1:0] cmt_tag,
  input logic [PTR_W-1:0] head_q,
  input logic [PTR_W-1:0] tail_q
);
  logic [TAG_W-1:0] exp_cmt_q;
  logic [TAG_W-1:0] tag_plus1, res_plus1;
  logic [PTR_W-1:0] occupancy;

  assign tag_plus1 = alloc_tag + 1'b1;
  assign res_plus1 = res_tag + 1'b1;
  assign occupancy = tail_q - head_q;

  always_ff @(posedge clk) begin
    if (rst)            exp_cmt_q <= '0;
    else if (cmt_valid) exp_cmt_q <= exp_cmt_q + 1'b1;
  end

  // R5: retirements follow tag order from reset
  p_commit_in_order_r5: assert property (@(posedge clk) disable iff (rst)
    cmt_valid |-> cmt_tag == exp_cmt_q);

  // R5: nothing retires from an empty ring
  p_no_commit_empty_r5: assert property (@(posedge clk) disable iff (rst)
    cmt_valid |-> $past(head_q != tail_q));

  // R3: occupancy never exceeds the depth
  p_occupancy_bound_r3: assert property (@(posedge clk) disable iff (rst)
    occupancy <= PTR_W'(ROB_DEPTH));

  // R3: a full ring refuses allocation
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (occupancy == PTR_W'(ROB_DEPTH)) |-> !alloc_ready);

  // R2: tags advance by one per accepted allocation
  p_alloc_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && alloc_ready) |=> alloc_tag == $past(tag_plus1));

  // R9: next tag after a misprediction follows the branch
  p_rollback_tail_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_mispredict) |=> alloc_tag == $past(res_plus1));
endmodule

bind rob_rename rob_rename_chk #(.ROB_DEPTH(ROB_DEPTH)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .alloc_valid    (alloc_valid),
  .alloc_ready    (alloc_ready),
  .alloc_tag      (alloc_tag),
  .res_valid      (res_valid),
  .res_mispredict (res_mispredict),
  .res_tag        (res_tag),
  .cmt_valid      (cmt_valid),
  .cmt_tag        (cmt_tag),
  .head_q         (head_q),
  .tail_q         (tail_q)
);

// File: tb/sim_rob_rename.sv
`timescale 1ns/1ps
module sim_rob_rename;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alloc_valid = 0, alloc_branch = 0, alloc_wr = 0;
  logic [2:0]  alloc_dest = '0;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        cmp_valid = 0, cmp_exc = 0;
  logic [2:0]  cmp_tag = '0;
  logic [15:0] cmp_data = '0;
  logic        res_valid = 0, res_mispredict = 0;
  logic [2:0]  res_tag = '0;
  logic [2:0]  lookup_areg = '0;
  logic        lkp_busy;
  logic [2:0]  lkp_tag;
  logic [15:0] lkp_data;
  logic        cmt_valid, cmt_wr, cmt_exc;
  logic [2:0]  cmt_tag, cmt_areg;
  logic [15:0] cmt_data;

  int checks = 0;
  int errors = 0;
  int lg_n = 0;
  int lg_tag [64], lg_areg [64], lg_data [64], lg_wr [64], lg_exc [64];

  always #10 clk = ~clk;

  rob_rename u0 (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_branch(alloc_branch), .alloc_wr(alloc_wr),
    .alloc_dest(alloc_dest), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
    .res_valid(res_valid), .res_tag(res_tag), .res_mispredict(res_mispredict),
    .lookup_areg(lookup_areg), .lkp_busy(lkp_busy), .lkp_tag(lkp_tag), .lkp_data(lkp_data),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_wr(cmt_wr), .cmt_areg(cmt_areg),
    .cmt_data(cmt_data), .cmt_exc(cmt_exc)
  );

  always @(negedge clk) begin
    if (!rst && cmt_valid && lg_n < 64) begin
      lg_tag[lg_n]  = cmt_tag;
      lg_areg[lg_n] = cmt_areg;
      lg_data[lg_n] = cmt_data;
      lg_wr[lg_n]   = cmt_wr;
      lg_exc[lg_n]  = cmt_exc;
      lg_n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_alloc(input bit br, input bit wr, input int dest, input int exp_tag, input string req);
    alloc_valid = 1; alloc_branch = br; alloc_wr = wr; alloc_dest = 3'(dest);
    #1;
    chk(req, "alloc_ready", alloc_ready, 1);
    chk(req, "alloc_tag", alloc_tag, exp_tag);
    step();
    alloc_valid = 0; alloc_branch = 0; alloc_wr = 0;
  endtask

  task automatic complete(input int tag, input int data, input bit exc);
    cmp_valid = 1; cmp_tag = 3'(tag); cmp_data = 16'(data); cmp_exc = exc;
    step();
    cmp_valid = 0; cmp_exc = 0;
  endtask

  task automatic resolve(input int tag, input bit mis);
    res_valid = 1; res_tag = 3'(tag); res_mispredict = mis;
    step();
    res_valid = 0; res_mispredict = 0;
  endtask

  task automatic peek(input int a, output int busy, output int tag, output int data);
    lookup_areg = 3'(a);
    step(2);
    busy = lkp_busy; tag = lkp_tag; data = lkp_data;
  endtask

  task automatic ready_for(input bit br, input int exp, input string req, input string what);
    alloc_valid = 0; alloc_branch = br;
    #1;
    chk(req, what, alloc_ready, exp);
    alloc_branch = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int b, t, d, base;
    step(3);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    #1;
    chk("R1", "alloc_ready", alloc_ready, 1);
    chk("R1", "alloc_tag", alloc_tag, 0);
    chk("R1", "cmt_valid", cmt_valid, 0);
    for (int a = 0; a < 8; a++) begin
      peek(a, b, t, d);
      chk("R1", "busy after reset", b, 0);
    end

    // R2 sequential tags, R4 map entries, R3 full
    for (int i = 0; i < 8; i++) do_alloc(0, 1, i, i, "R2");
    ready_for(0, 0, "R3", "ready when full");
    for (int a = 0; a < 8; a++) begin
      peek(a, b, t, d);
      chk("R4", "busy", b, 1);
      chk("R4", "tag", t, a);
    end

    // R5 head blocks younger completed entries
    for (int k = 7; k >= 1; k--) complete(k, 16'h100 + k, 0);
    step(3);
    chk("R5", "commits before head done", lg_n, 0);
    complete(0, 16'h100, 0);
    step(10);
    chk("R5", "commit count", lg_n, 8);
    for (int k = 0; k < 8; k++) begin
      chk("R5", "commit tag order", lg_tag[k], k);
      chk("R6", "commit areg", lg_areg[k], k);
      chk("R6", "commit data", lg_data[k], 16'h100 + k);
      chk("R6", "commit wr", lg_wr[k], 1);
    end
    ready_for(0, 1, "R3", "ready after drain");
    chk("R3", "wrapped tag", alloc_tag, 0);
    for (int a = 0; a < 8; a++) begin
      peek(a, b, t, d);
      chk("R7", "busy cleared", b, 0);
      chk("R7", "arch value", d, 16'h100 + a);
    end

    // R8 younger writer keeps mapping
    do_alloc(0, 1, 2, 0, "R8");
    do_alloc(0, 1, 2, 1, "R8");
    complete(0, 16'h200, 0);
    step(3);
    peek(2, b, t, d);
    chk("R8", "busy kept", b, 1);
    chk("R8", "younger tag", t, 1);
    complete(1, 16'h201, 0);
    step(3);
    peek(2, b, t, d);
    chk("R8", "busy after both", b, 0);
    chk("R8", "final value", d, 16'h201);

    // R9 / R10 / R12 nested branches, roll back at the older one
    do_alloc(0, 1, 3, 2, "R9");
    do_alloc(1, 0, 0, 3, "R9");
    do_alloc(0, 1, 3, 4, "R9");
    do_alloc(1, 0, 0, 5, "R9");
    do_alloc(0, 1, 4, 6, "R9");
    peek(3, b, t, d);
    chk("R4", "tag before rollback", t, 4);
    peek(4, b, t, d);
    chk("R4", "busy before rollback", b, 1);
    res_valid = 1; res_tag = 3; res_mispredict = 1; alloc_valid = 1;
    #1;
    chk("R9", "no alloc during mispredict", alloc_ready, 0);
    alloc_valid = 0;
    step();
    res_valid = 0; res_mispredict = 0;
    #1;
    chk("R9", "tag after rollback", alloc_tag, 4);
    peek(3, b, t, d);
    chk("R10", "restored busy", b, 1);
    chk("R10", "restored tag", t, 2);
    peek(4, b, t, d);
    chk("R10", "restored idle", b, 0);
    chk("R10", "restored value", d, 16'h104);
    for (int i = 0; i < 4; i++) do_alloc(1, 0, 0, 4 + i, "R12");
    ready_for(1, 0, "R11", "branch ready with pool empty");
    ready_for(0, 1, "R11", "plain ready with pool empty");

    // R13 correct resolutions in any order
    resolve(6, 0);
    ready_for(1, 1, "R13", "branch ready after release");
    do_alloc(1, 0, 0, 0, "R13");
    ready_for(1, 0, "R13", "pool full again");
    resolve(7, 0);
    resolve(4, 0);
    resolve(0, 0);
    resolve(5, 0);
    step(3);
    chk("R5", "blocked behind tag 2", lg_n, 10);
    complete(2, 16'h300, 1);
    step(12);
    chk("R5", "commits after release", lg_n, 17);
    chk("R6", "exc flag", lg_exc[10], 1);
    chk("R6", "exc data", lg_data[10], 16'h300);
    chk("R6", "exc areg", lg_areg[10], 3);
    base = 3;
    for (int k = 11; k < 17; k++) begin
      chk("R5", "branch commit tag", lg_tag[k], (base + k - 11) % 8);
      chk("R6", "branch no write", lg_wr[k], 0);
      chk("R6", "branch no exc", lg_exc[k], 0);
    end
    chk("R13", "resolved branch retired", lg_tag[16], 0);
    peek(3, b, t, d);
    chk("R7", "busy after exc commit", b, 0);
    chk("R7", "value after exc commit", d, 16'h300);

    // R10 checkpoint forgets a mapping retired while it was held
    do_alloc(0, 1, 5, 1, "R10");
    do_alloc(1, 0, 0, 2, "R10");
    do_alloc(0, 1, 5, 3, "R10");
    complete(1, 16'h400, 0);
    step(4);
    peek(5, b, t, d);
    chk("R8", "younger holds after commit", t, 3);
    resolve(2, 1);
    #1;
    chk("R9", "tag after second rollback", alloc_tag, 3);
    peek(5, b, t, d);
    chk("R10", "retired mapping dropped", b, 0);
    chk("R10", "value after restore", d, 16'h400);
    step(4);
    chk("R5", "final commit count", lg_n, 19);
    chk("R5", "branch retired last", lg_tag[18], 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule